// File: doc/BRIEF.md
# Spread-Spectrum Light-Load Switching Oscillator

This block paces a current-mode power converter controller. It sends one single-cycle start pulse at the beginning of every switching period, and it opens a maximum on-time window that begins with that pulse. The length of each period is chosen again at every reload. It is taken from a band of allowed periods, and the position inside the band comes from a free-running pseudo-random register mixed with the low bits of the compensation code. This spreads the switching energy over a range of frequencies.

The compensation voltage arrives as a code in millivolts. When the load is high, the band sits around the nominal frequency. As the compensation code falls, the band moves linearly towards a much lower frequency band, which reduces switching loss at light load. Below a lower threshold, switching stops entirely (burst idle). It starts again only once the code rises above a higher threshold. An enable input and an external hold input can also suppress pulses.

Top module: `sso_green_osc`

## Requirements
- R1: During and straight after reset, `start_o`, `on_allow_o` and `burst_idle_o` are all 0.
- R2: With a code of 1900 mV or more, each interval between start pulses lies in [CLK_KHZ/53, CLK_KHZ/47] clock cycles (188 to 212 at the default 10000).
- R3: With a code of 800 mV or less (and switching active), each interval lies in [CLK_KHZ/23, CLK_KHZ/21] cycles (434 to 476 by default).
- R4: For a code c strictly between 800 and 1900, with d = 1900 - c, the interval lies in [Fmin + (Lmin-Fmin)*d/1100, Fmax + (Lmax-Fmax)*d/1100]. Here Fmin/Fmax and Lmin/Lmax are the R2 and R3 limits, and the divisions are integer divisions.
- R5: The offset inside the band comes from a 16-bit LFSR (taps 16,14,13,11) that steps on every clock, with its two bytes XORed with each other and with code bits [7:0]. Successive intervals at a fixed code are therefore not all equal.
- R6: A code below 400 sets `burst_idle_o` on the next clock edge. While it is set, no start pulses appear.
- R7: A code above 450 clears `burst_idle_o` on the next edge, and the first start pulse follows on the edge after that. A code from 400 to 450 keeps the current idle state.
- R8: While `en_i` is 0 or `hold_i` is 1, no start pulse is issued on the following edge.
- R9: `on_allow_o` is high for exactly CLK_KHZ*133/10000 cycles (133 by default), starting in the cycle of each start pulse.
- R10: `start_o` is high for one clock cycle per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Switching enable |
| hold_i | input | 1 | External gate that forces idle |
| comp_mv_i | input | 12 | Compensation voltage code, mV |
| start_o | output | 1 | Switching cycle start pulse |
| on_allow_o | output | 1 | Maximum on-time window |
| burst_idle_o | output | 1 | Burst hysteresis state, 1 = idle |

## Verification
A change of the burst state and a period reload can fall on the same edge. When a code above 450 ends burst idle, the counter already holds zero. The reload then has to happen exactly one edge after the state clears, so the bench checks for a pulse at the second sample after the change. Entry into burst idle can likewise coincide with a pending reload. The bench allows that one edge and then requires silence across a long window, including in the hysteresis band.

// File: rtl/sso_pkg.sv
package sso_pkg;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // Fibonacci step, polynomial x^16 + x^14 + x^13 + x^11 + 1
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/sso_lfsr.sv
module sso_lfsr (
    input  logic        clk_i,
    input  logic        rst_ni,
    output logic [15:0] state_o
);
    import sso_pkg::*;

    logic [15:0] st_d, st_q;

    always_comb begin
        st_d = lfsr_step(st_q);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= LFSR_SEED;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

    // R5: the register never locks up in the all-zero state
    a_r5_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q != 16'h0000);

endmodule

// File: rtl/sso_burst.sv
module sso_burst #(
    parameter int CW       = 12,
    parameter int ENTER_MV = 400,
    parameter int EXIT_MV  = 450
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] comp_mv_i,
    output logic          idle_o
);
    logic idle_d, idle_q;

    always_comb begin
        idle_d = idle_q;
        if (32'(comp_mv_i) < 32'(ENTER_MV))      idle_d = 1'b1;
        else if (32'(comp_mv_i) > 32'(EXIT_MV))  idle_d = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) idle_q <= 1'b0;
        else         idle_q <= idle_d;
    end

    assign idle_o = idle_q;

    a_r6_enter_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(comp_mv_i) < 32'(ENTER_MV)) |=> idle_q);
    a_r7_leave_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(comp_mv_i) > 32'(EXIT_MV)) |=> !idle_q);
    a_r7_band_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(comp_mv_i) >= 32'(ENTER_MV) && 32'(comp_mv_i) <= 32'(EXIT_MV)) |=> $stable(idle_q));

endmodule

// File: rtl/sso_band.sv
module sso_band #(
    parameter int CW    = 12,
    parameter int HI_MV = 1900,
    parameter int LO_MV = 800,
    parameter int FMIN  = 188,
    parameter int FMAX  = 212,
    parameter int LMIN  = 434,
    parameter int LMAX  = 476,
    parameter int PW    = 9
) (
    input  logic [CW-1:0] comp_mv_i,
    input  logic [7:0]    mix_i,
    output logic [PW-1:0] period_o
);
    localparam int SPAN_MV = HI_MV - LO_MV;

    logic [31:0] c, d, lo, hi, off;

    always_comb begin
        c = 32'(comp_mv_i);
        if (c >= 32'(HI_MV))      d = 32'd0;
        else if (c <= 32'(LO_MV)) d = 32'(SPAN_MV);
        else                      d = 32'(HI_MV) - c;
        // linear interpolation of both edges, in period counts
        lo = 32'(FMIN) + (32'(LMIN - FMIN) * d) / 32'(SPAN_MV);
        hi = 32'(FMAX) + (32'(LMAX - FMAX) * d) / 32'(SPAN_MV);
        if (lo > 32'(LMIN)) lo = 32'(LMIN);
        if (hi > 32'(LMAX)) hi = 32'(LMAX);
        off = ((hi - lo + 32'd1) * 32'(mix_i)) >> 8;
        period_o = PW'(lo + off);
    end

endmodule

// File: rtl/sso_green_osc.sv
module sso_green_osc #(
    parameter int CLK_KHZ  = 10000,
    parameter int CW       = 12,
    parameter int HI_MV    = 1900,
    parameter int LO_MV    = 800,
    parameter int ENTER_MV = 400,
    parameter int EXIT_MV  = 450
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          hold_i,
    input  logic [CW-1:0] comp_mv_i,
    output logic          start_o,
    output logic          on_allow_o,
    output logic          burst_idle_o
);
    localparam int FMIN   = CLK_KHZ / 53;
    localparam int FMAX   = CLK_KHZ / 47;
    localparam int LMIN   = CLK_KHZ / 23;
    localparam int LMAX   = CLK_KHZ / 21;
    localparam int ONTIME = CLK_KHZ * 133 / 10000;
    localparam int PW     = $clog2(LMAX + 1);
    localparam int OW     = $clog2(ONTIME + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic [OW-1:0] on;
        logic          start;
    } osc_t;

    osc_t          s_d, s_q;
    logic [15:0]   lfsr;
    logic [7:0]    mix;
    logic [PW-1:0] period;
    logic          idle;
    logic          run;

    sso_lfsr u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_o (lfsr)
    );

    sso_burst #(.CW(CW), .ENTER_MV(ENTER_MV), .EXIT_MV(EXIT_MV)) u_burst (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .comp_mv_i (comp_mv_i),
        .idle_o    (idle)
    );

    assign mix = lfsr[7:0] ^ lfsr[15:8] ^ comp_mv_i[7:0];

    sso_band #(
        .CW(CW), .HI_MV(HI_MV), .LO_MV(LO_MV),
        .FMIN(FMIN), .FMAX(FMAX), .LMIN(LMIN), .LMAX(LMAX), .PW(PW)
    ) u_band (
        .comp_mv_i (comp_mv_i),
        .mix_i     (mix),
        .period_o  (period)
    );

    always_comb begin
        run     = en_i & ~hold_i & ~idle;
        s_d     = s_q;
        s_d.start = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == '0) begin
            s_d.cnt   = period - PW'(1);
            s_d.start = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - PW'(1);
        end
        if (s_d.start)          s_d.on = OW'(ONTIME);
        else if (s_q.on != '0)  s_d.on = s_q.on - OW'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign start_o      = s_q.start;
    assign on_allow_o   = (s_q.on != '0);
    assign burst_idle_o = idle;

    a_r8_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !start_o);
    a_r8_hold_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> !start_o);
    a_r6_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_idle_o && $past(burst_idle_o)) |-> !start_o);
    a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
    a_r9_window_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> on_allow_o);
    a_r4_reload_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> (32'(s_q.cnt) >= 32'(FMIN - 1) && 32'(s_q.cnt) <= 32'(LMAX - 1)));

endmodule

// File: tb/sso_green_osc_tb.sv
`timescale 1ns/1ps
module sso_green_osc_tb_top;

    localparam int CLK_KHZ = 10000;
    localparam int FMIN = CLK_KHZ / 53, FMAX = CLK_KHZ / 47;
    localparam int LMIN = CLK_KHZ / 23, LMAX = CLK_KHZ / 21;
    localparam int ONTIME = CLK_KHZ * 133 / 10000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hold = 1'b0;
    logic [11:0] comp = 12'd0;
    logic        start, on_allow, idle;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sso_green_osc #(.CLK_KHZ(CLK_KHZ)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hold_i(hold),
        .comp_mv_i(comp), .start_o(start), .on_allow_o(on_allow),
        .burst_idle_o(idle)
    );

    function automatic int band_lo(int c);
        int d = (c >= 1900) ? 0 : (c <= 800) ? 1100 : 1900 - c;
        return FMIN + (LMIN - FMIN) * d / 1100;
    endfunction
    function automatic int band_hi(int c);
        int d = (c >= 1900) ? 0 : (c <= 800) ? 1100 : 1900 - c;
        return FMAX + (LMAX - FMAX) * d / 1100;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // wait for a pulse, then return cycles to the next one
    task automatic next_interval(output int n);
        int t = 0;
        while (!start && t < 3000) begin @(negedge clk); t++; end
        n = 0;
        @(negedge clk); n++;
        check(!start, "R10 pulse width", 1, 0);
        while (!start && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic count_pulses(input int ncyc, output int n);
        n = 0;
        for (int i = 0; i < ncyc; i++) begin @(negedge clk); if (start) n++; end
    endtask

    task automatic band_run(input int c, input int reps, input string req);
        int iv;
        comp = 12'(c);
        next_interval(iv); // settle: first interval after a code change
        for (int k = 0; k < reps; k++) begin
            next_interval(iv);
            check(iv >= band_lo(c) && iv <= band_hi(c), req, iv, band_lo(c));
        end
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int iv, prev, n, distinct, hi_cnt;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        check(!start && !on_allow && !idle, "R1 reset outputs", {start, on_allow, idle}, 0);
        comp = 12'd2500;
        rst_n = 1'b1;
        @(negedge clk);
        check(!start && !on_allow && !idle, "R1 after reset", {start, on_allow, idle}, 0);
        en = 1'b1;

        // R2 full band and R5 spreading
        next_interval(iv);
        prev = -1; distinct = 0;
        for (int k = 0; k < 20; k++) begin
            next_interval(iv);
            check(iv >= FMIN && iv <= FMAX, "R2 full band", iv, FMIN);
            if (iv != prev) distinct++;
            prev = iv;
        end
        check(distinct > 3, "R5 spread present", distinct, 4);

        // R9 on-time window
        while (!start) @(negedge clk);
        hi_cnt = 0;
        while (on_allow && hi_cnt < 1000) begin hi_cnt++; @(negedge clk); end
        check(hi_cnt == ONTIME, "R9 on window", hi_cnt, ONTIME);

        // R3 light band, R4 fold-back directed and random
        band_run(600, 8, "R3 light band");
        band_run(800, 4, "R3 light band edge");
        band_run(1900, 4, "R2 band edge");
        band_run(1000, 5, "R4 fold-back");
        band_run(1350, 5, "R4 fold-back");
        band_run(1700, 5, "R4 fold-back");
        for (int r = 0; r < 12; r++) band_run(int'($urandom_range(801, 1899)), 3, "R4 random code");
        for (int r = 0; r < 4; r++)  band_run(int'($urandom_range(1900, 4095)), 3, "R2 random code");

        // R6 burst entry
        comp = 12'd300;
        @(negedge clk); @(negedge clk);
        check(idle, "R6 idle set", idle, 1);
        count_pulses(1500, n);
        check(n == 0, "R6 silent", n, 0);
        // R7 hysteresis band holds idle
        comp = 12'd430;
        count_pulses(1500, n);
        check(n == 0 && idle, "R7 band keeps idle", n, 0);
        // R7 exit and restart timing
        comp = 12'd460;
        @(negedge clk);
        check(!idle, "R7 idle cleared", idle, 0);
        @(negedge clk);
        check(start, "R7 first pulse", start, 1);
        comp = 12'd430;
        count_pulses(2000, n);
        check(n >= 3 && !idle, "R7 band keeps running", n, 4);

        // R8 enable and hold gating
        en = 1'b0;
        @(negedge clk); @(negedge clk);
        count_pulses(2000, n);
        check(n == 0, "R8 enable low", n, 0);
        en = 1'b1; hold = 1'b1;
        @(negedge clk); @(negedge clk);
        count_pulses(2000, n);
        check(n == 0, "R8 hold high", n, 0);
        hold = 1'b0;
        count_pulses(2000, n);
        check(n >= 3, "R8 resume", n, 4);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule